// File: doc/BRIEF.md
# Configurable Synchronous Serial Shifter

This block moves one byte at a time over a three-wire synchronous serial link: a shift clock, a data output and a data input. Before a transfer, a byte is written into the shift register through a parallel load port. A start strobe then begins the transfer. Each falling shift-clock edge presents one outgoing bit, and each rising edge samples one incoming bit. After eight rising edges the received byte sits in the same register, and a one-cycle completion pulse is raised.

Three static configuration inputs set the transfer. The first selects full duplex or receive only; in receive only the output wire stays high. The second selects the bit order, which applies to both directions. The third selects the clock source. With the internal source, a tick input toggles the shift clock, and the block drives the clock pin. With the external source, the clock pin is an input: it goes through a synchronizer, and its edges are detected in the system clock domain.

Top module: `ser_shifter`

## Requirements
- R1: After reset, `busy` and `doneIrq` are 0, `sckOut` is 1 and `sdo` is 1. `sckOe` equals the inverse of `cfgExtClk`.
- R2: A `start` pulse while idle raises `busy` on the next cycle. A transfer always moves exactly 8 bits. On the system edge that acts on the 8th rising shift-clock event, `busy` falls, `doneIrq` rises, and `rxData` holds the received byte.
- R3: With `cfgMsbFirst`=1, bit 7 of the loaded byte is sent first. The first bit sampled ends up in bit 7 of `rxData`.
- R4: With `cfgMsbFirst`=0, bit 0 of the loaded byte is sent first. The first bit sampled ends up in bit 0 of `rxData`.
- R5: With `cfgRxOnly`=1, `sdo` stays 1 throughout the transfer and the loaded byte is never driven out. Reception still completes normally.
- R6: `sdo` changes only on falling shift-clock events, and `sdi` is sampled only on rising shift-clock events.
- R7: With `cfgExtClk`=0, each `intTick` during a transfer toggles `sckOut`. `sckOut` starts from high, and the first toggle is a falling edge. Without `intTick`, `sckOut` holds its value.
- R8: With `cfgExtClk`=1, a level change on `sckIn` takes effect on the third system clock edge after it is applied (a two-flop synchronizer followed by edge detection). `sckOut` stays high.
- R9: A `start` or `loadEn` while `busy` is 1 has no effect on the bits sent, the bits received or the transfer length.
- R10: `doneIrq` is high for exactly one cycle per transfer.
- R11: When idle, `sdo` is 1. It returns to 1 on the cycle the transfer completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgRxOnly | input | 1 | 1 = receive only, 0 = full duplex |
| cfgMsbFirst | input | 1 | 1 = MSB first, 0 = LSB first |
| cfgExtClk | input | 1 | 1 = shift clock from sckIn, 0 = internal ticks |
| intTick | input | 1 | Internal shift-clock half-period strobe (e.g. from a timer) |
| loadEn | input | 1 | Write loadData into the shift register (idle only) |
| loadData | input | DATA_W | Byte to transmit |
| start | input | 1 | Begin a transfer (idle only) |
| rxData | output | DATA_W | Shift register contents; received byte after completion |
| busy | output | 1 | Transfer in progress |
| doneIrq | output | 1 | One-cycle completion pulse |
| sckIn | input | 1 | Shift clock pin input |
| sckOut | output | 1 | Shift clock pin output value |
| sckOe | output | 1 | Shift clock pin output enable |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
The bound checker verifies these on every cycle:
- the completion pulse lasts one cycle and coincides with the end of `busy`;
- the clock idles high;
- each internal tick toggles the clock, and nothing else does;
- `sdo` holds across a rising shift edge;
- `sdo` is idle high outside transfers;
- a start while idle is accepted.

Bit order, the exact transfer length, the received byte, receive-only silencing, the synchronizer latency and the immunity to mid-transfer strobes depend on whole sequences of stimulus. Only the bench's sweeps over all byte values and configurations can show those.

// File: rtl/ser_shifter_pkg.sv
package ser_shifter_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_XFER = 1'b1
  } shState_t;

  typedef struct packed {
    logic load;    // capture parallel data
    logic fall;    // present next outgoing bit
    logic rise;    // shift in sampled bit
    logic finish;  // last sampling edge of the transfer
  } shStrobe_t;

endpackage

// File: rtl/ser_shift_clkfront.sv
module ser_shift_clkfront #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic cfgExtClk,
  input  logic busy,
  input  logic intTick,
  input  logic sckIn,
  output logic sckOut,
  output logic fallEv,
  output logic riseEv
);

  logic [SYNC_STAGES:0] syncQ;
  logic sckReg;
  logic extCur, extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-1:0], sckIn};
    end
  end

  assign extCur  = syncQ[SYNC_STAGES-1];
  assign extPrev = syncQ[SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckReg <= 1'b1;
    end else if (!busy || cfgExtClk) begin
      sckReg <= 1'b1;
    end else if (intTick) begin
      sckReg <= ~sckReg;
    end
  end

  always_comb begin
    if (cfgExtClk) begin
      fallEv = extPrev & ~extCur;
      riseEv = ~extPrev & extCur;
    end else begin
      fallEv = busy & intTick & sckReg;
      riseEv = busy & intTick & ~sckReg;
    end
  end

  assign sckOut = sckReg;

endmodule

// File: rtl/ser_shift_ctrl.sv
module ser_shift_ctrl
  import ser_shifter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      loadEn,
  input  logic      fallEv,
  input  logic      riseEv,
  output logic      busy,
  output logic      doneIrq,
  output shStrobe_t strobe
);

  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  shState_t       state;
  logic [CNT_W-1:0] bitCnt;
  logic           lowHalf;
  logic           doneQ;
  logic           inXfer;
  logic           takeFall, takeRise, lastRise;

  assign inXfer   = (state == ST_XFER);
  assign takeFall = inXfer & fallEv & ~lowHalf;
  assign takeRise = inXfer & riseEv & lowHalf;
  assign lastRise = takeRise & (bitCnt == LAST_BIT);

  always_comb begin
    strobe.load   = loadEn & ~inXfer;
    strobe.fall   = takeFall;
    strobe.rise   = takeRise;
    strobe.finish = lastRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      lowHalf <= 1'b0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= lastRise;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_XFER;
            bitCnt  <= '0;
            lowHalf <= 1'b0;
          end
        end
        default: begin
          if (takeFall) lowHalf <= 1'b1;
          if (takeRise) begin
            lowHalf <= 1'b0;
            bitCnt  <= bitCnt + 1'b1;
          end
          if (lastRise) state <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy    = inXfer;
  assign doneIrq = doneQ;

endmodule

// File: rtl/ser_shift_datapath.sv
module ser_shift_datapath
  import ser_shifter_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgMsbFirst,
  input  logic              cfgRxOnly,
  input  shStrobe_t         strobe,
  input  logic [DATA_W-1:0] loadData,
  input  logic              sdi,
  output logic [DATA_W-1:0] shiftReg,
  output logic              sdo
);

  logic txBit;
  logic outBit;
  logic [DATA_W-1:0] shifted;

  generate
    if (DATA_W > 1) begin : g_multi
      always_comb begin
        outBit  = cfgMsbFirst ? shiftReg[DATA_W-1] : shiftReg[0];
        shifted = cfgMsbFirst ? {shiftReg[DATA_W-2:0], sdi}
                              : {sdi, shiftReg[DATA_W-1:1]};
      end
    end else begin : g_single
      always_comb begin
        outBit  = shiftReg[0];
        shifted = sdi;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobe.load) begin
      shiftReg <= loadData;
    end else if (strobe.rise) begin
      shiftReg <= shifted;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBit <= 1'b1;
    end else if (strobe.fall) begin
      txBit <= outBit;
    end else if (strobe.finish) begin
      txBit <= 1'b1;
    end
  end

  assign sdo = cfgRxOnly ? 1'b1 : txBit;

endmodule

// File: rtl/ser_shifter.sv
module ser_shifter
  import ser_shifter_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgRxOnly,
  input  logic              cfgMsbFirst,
  input  logic              cfgExtClk,
  input  logic              intTick,
  input  logic              loadEn,
  input  logic [DATA_W-1:0] loadData,
  input  logic              start,
  output logic [DATA_W-1:0] rxData,
  output logic              busy,
  output logic              doneIrq,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  output logic              sdo,
  input  logic              sdi
);

  shStrobe_t strobe;
  logic fallEv, riseEv;

  ser_shift_clkfront #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk      (clk),
    .rstN     (rstN),
    .cfgExtClk(cfgExtClk),
    .busy     (busy),
    .intTick  (intTick),
    .sckIn    (sckIn),
    .sckOut   (sckOut),
    .fallEv   (fallEv),
    .riseEv   (riseEv)
  );

  ser_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .loadEn (loadEn),
    .fallEv (fallEv),
    .riseEv (riseEv),
    .busy   (busy),
    .doneIrq(doneIrq),
    .strobe (strobe)
  );

  ser_shift_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cfgMsbFirst(cfgMsbFirst),
    .cfgRxOnly  (cfgRxOnly),
    .strobe     (strobe),
    .loadData   (loadData),
    .sdi        (sdi),
    .shiftReg   (rxData),
    .sdo        (sdo)
  );

  assign sckOe = ~cfgExtClk;

endmodule

// File: rtl/ser_shifter_chk.sv
module ser_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic cfgExtClk,
  input logic intTick,
  input logic start,
  input logic busy,
  input logic doneIrq,
  input logic sckOut,
  input logic sdo
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq); // R10

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> (!busy && $past(busy))); // R2

  AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R2

  AST_SCK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sckOut); // R7

  AST_TICK_TOGGLES: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgExtClk && intTick) |=> (sckOut != $past(sckOut))); // R7

  AST_SCK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgExtClk && !intTick) |=> $stable(sckOut)); // R7

  AST_SDO_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cfgExtClk && $rose(sckOut)) |-> $stable(sdo)); // R6

  AST_SDO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sdo); // R11

endmodule

bind ser_shifter ser_shifter_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgExtClk(cfgExtClk),
  .intTick  (intTick),
  .start    (start),
  .busy     (busy),
  .doneIrq  (doneIrq),
  .sckOut   (sckOut),
  .sdo      (sdo)
);

// File: tb/tb_ser_shifter.sv
`timescale 1ns/1ps
module tb_ser_shifter;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgRxOnly = 1'b0, cfgMsbFirst = 1'b1, cfgExtClk = 1'b0;
  logic intTick = 1'b0, loadEn = 1'b0, start = 1'b0;
  logic [7:0] loadData = '0;
  logic [7:0] rxData;
  logic busy, doneIrq, sckOut, sckOe, sdo;
  logic sckIn = 1'b1, sdi = 1'b0;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  ser_shifter dut (
    .clk(clk), .rstN(rstN), .cfgRxOnly(cfgRxOnly), .cfgMsbFirst(cfgMsbFirst),
    .cfgExtClk(cfgExtClk), .intTick(intTick), .loadEn(loadEn), .loadData(loadData),
    .start(start), .rxData(rxData), .busy(busy), .doneIrq(doneIrq), .sckIn(sckIn),
    .sckOut(sckOut), .sckOe(sckOe), .sdo(sdo), .sdi(sdi)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk) intTick = 1'b1;
    @(negedge clk) intTick = 1'b0;
  endtask

  task automatic extEdge(input logic lvl);
    @(negedge clk) sckIn = lvl;
    @(negedge clk);
    @(negedge clk);
    // R8: two edges after the change nothing has happened yet
    check(busy == 1'b1 && doneIrq == 1'b0, "R8 latency early", {busy, doneIrq}, 2);
    @(negedge clk);
  endtask

  // One complete transfer; bench acts as the far side of the link.
  task automatic xfer(input logic [7:0] tx, input logic [7:0] rx,
                      input logic msb, input logic rxo, input logic ext,
                      input bit meddle);
    int sdoErr = 0;
    int sckErr = 0;
    logic expBit;
    cfgMsbFirst = msb; cfgRxOnly = rxo; cfgExtClk = ext;
    @(negedge clk) loadEn = 1'b1; loadData = tx;
    @(negedge clk) loadEn = 1'b0; start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(sckOe == !ext, "R1 sckOe", sckOe, !ext);
    for (int i = 0; i < 8; i++) begin
      expBit = msb ? tx[7-i] : tx[i];
      if (ext) extEdge(1'b0); else tick();
      if (!ext && sckOut !== 1'b0) sckErr++;
      if (sdo !== (rxo ? 1'b1 : expBit)) sdoErr++;
      if (meddle && i == 3) begin
        @(negedge clk) start = 1'b1; loadEn = 1'b1; loadData = ~tx;
        @(negedge clk) start = 1'b0; loadEn = 1'b0;
      end
      sdi = msb ? rx[7-i] : rx[i];
      if (ext) extEdge(1'b1); else tick();
      if (sckOut !== 1'b1) sckErr++;
      // R6: sdo must not move on the rising edge (except final idle return)
      if (i < 7 && sdo !== (rxo ? 1'b1 : expBit)) sdoErr++;
      if (i < 7) check(busy == 1'b1 && doneIrq == 1'b0, "R2 no early done", {busy, doneIrq}, 2);
    end
    check(sdoErr == 0, rxo ? "R5 sdo held high" : (msb ? "R3 tx order/R6" : "R4 tx order/R6"), sdoErr, 0);
    check(sckErr == 0, ext ? "R8 sckOut stays high" : "R7 sck toggling", sckErr, 0);
    check(doneIrq == 1'b1 && busy == 1'b0, "R2 completion", {doneIrq, busy}, 2);
    check(rxData == rx, meddle ? "R9 rx unaffected" : (msb ? "R3 rx order" : "R4 rx order"), rxData, rx);
    check(sdo == 1'b1, "R11 sdo idle", sdo, 1);
    @(negedge clk);
    check(doneIrq == 1'b0, "R10 single-cycle done", doneIrq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && doneIrq == 0 && sckOut == 1 && sdo == 1,
          "R1 reset state", {busy, doneIrq, sckOut, sdo}, 3);
    rstN = 1'b1;
    @(negedge clk);
    check(sckOe == 1'b1, "R1 sckOe internal", sckOe, 1);
    // R7: ticks while idle do nothing
    tick();
    check(sckOut == 1'b1 && busy == 1'b0, "R7 idle tick ignored", {sckOut, busy}, 2);

    // Internal clock: all byte values, both orders, both modes
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 256; t++) begin
        xfer(8'(t), 8'(t * 29 + 113), m[0], m[1], 1'b0, (t % 16) == 5);
      end
    end

    // External clock: selected patterns, all configurations
    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 8; t++) begin
        xfer(8'(t * 37 + 1), 8'(~(t * 53)), m[0], m[1], 1'b1, t == 2);
      end
    end

    // R9: start held while busy does not extend the transfer
    xfer(8'hA5, 8'h3C, 1'b1, 1'b0, 1'b0, 1'b1);

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule